// File: doc/BRIEF.md
# Dual-Polarization Correlator Integrator

This block takes two streams of complex channel samples, one per polarization, each with a 4-bit signed real part and a 4-bit signed imaginary part. For every frequency channel it forms four products: the power of polarization A, the power of polarization B, and the real and imaginary parts of A times the conjugate of B. It adds each product into its own per-channel accumulator over a programmable number of spectra. This sets the time resolution of the integrated spectrum.

A spectrum arrives as channels 0 to CHANNELS-1 in ascending order. Input cycles may carry no data between them. The accumulators sit in per-channel memory and are updated by a read-modify-write pipeline. The first spectrum of each integration writes the new product over the stored value, so the memory never needs a separate clear pass. During the last spectrum of an integration, each channel's completed sums are sent out in channel order as that channel is processed. Each output is tagged with its channel number, and the final channel carries an end flag.

Top module: `corr_integrator`

## Requirements
- R1: `out_aa` carries the sum over the integration of re²+im² of polarization A, and `out_bb` does the same for polarization B. Both are unsigned and zero-extended to ACC_W bits.
- R2: `out_cr` carries the sum of (a_re·b_re + a_im·b_im), and `out_ci` carries the sum of (a_im·b_re − a_re·b_im). All sample inputs are 4-bit two's complement. The products are signed and sign-extended to ACC_W bits, and the sums wrap modulo 2^ACC_W.
- R3: Accumulation is kept separately for each channel. The first spectrum of an integration loads the product into the accumulator; the following spectra add to it.
- R4: The integration length is sampled from `int_len` when channel 0 of the first spectrum of an integration arrives. Changes made during an integration take effect only at the next integration.
- R5: An `int_len` value of 0 behaves as a length of 1.
- R6: In the final spectrum of an integration, the completed sums for each channel appear on the output exactly two clock cycles after that channel's input cycle. `out_valid` is 1, `out_chan` equals the channel, and `out_last` is 1 only for channel CHANNELS-1.
- R7: `out_valid` stays 0 for the spectra of an integration other than the final one, and for cycles with no input.
- R8: Input channels arrive in ascending order 0..CHANNELS-1 for every spectrum, and the same channel never appears on two consecutive input cycles. Idle cycles between channels are allowed.
- R9: While `rst_n` is low, `out_valid` is 0, and the next integration starts fresh after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_len | input | LEN_W (16) | Number of spectra per integration (0 treated as 1) |
| in_valid | input | 1 | Input sample valid |
| in_chan | input | CHW ($clog2(CHANNELS)) | Channel index of the input sample |
| in_a_re | input | SAMP_W (4) | Polarization A real part, signed |
| in_a_im | input | SAMP_W (4) | Polarization A imaginary part, signed |
| in_b_re | input | SAMP_W (4) | Polarization B real part, signed |
| in_b_im | input | SAMP_W (4) | Polarization B imaginary part, signed |
| out_valid | output | 1 | Completed sums valid |
| out_last | output | 1 | Marks the last channel of a dump |
| out_chan | output | CHW | Channel number of the dumped sums |
| out_aa | output | ACC_W (32) | Integrated power, polarization A |
| out_bb | output | ACC_W (32) | Integrated power, polarization B |
| out_cr | output | ACC_W (32) | Integrated cross product, real part |
| out_ci | output | ACC_W (32) | Integrated cross product, imaginary part |

## Verification
The bench builds the block with CHANNELS=8 and keeps the sample and accumulator widths at their defaults. With eight channels, a full spectrum takes only a few cycles. This lets the run cover many integrations: lengths of 1, 2, 3 and 5, a length change made partway through an integration, a zero length, and extreme negative samples. Idle cycles placed at random between channels test that the two-cycle output latency is tied to each channel's input cycle and not to a fixed schedule.

// File: rtl/corr_pkg.sv
package corr_pkg;
  parameter int SAMP_W = 4;
  parameter int PROD_W = 2 * SAMP_W + 1;
  parameter int ACC_W  = 32;
  parameter int LEN_W  = 16;
  parameter int N_LANE = 4;
  // lane order: 0 power A, 1 power B, 2 cross real, 3 cross imaginary
endpackage

// File: rtl/corr_cmul.sv
module corr_cmul
  import corr_pkg::*;
(
  input  logic [SAMP_W-1:0] a_re,
  input  logic [SAMP_W-1:0] a_im,
  input  logic [SAMP_W-1:0] b_re,
  input  logic [SAMP_W-1:0] b_im,
  output logic [PROD_W-1:0] p_aa,
  output logic [PROD_W-1:0] p_bb,
  output logic [PROD_W-1:0] p_cr,
  output logic [PROD_W-1:0] p_ci
);
  logic signed [PROD_W-1:0] ar, ai, br, bi;

  always_comb begin
    ar   = PROD_W'($signed(a_re));
    ai   = PROD_W'($signed(a_im));
    br   = PROD_W'($signed(b_re));
    bi   = PROD_W'($signed(b_im));
    p_aa = ar * ar + ai * ai;
    p_bb = br * br + bi * bi;
    p_cr = ar * br + ai * bi;
    p_ci = ai * br - ar * bi;
  end
endmodule

// File: rtl/corr_acc_lane.sv
module corr_acc_lane
  import corr_pkg::*;
#(
  parameter int CHANNELS = 512,
  parameter bit SIGNED_P = 1'b0,
  localparam int CHW = $clog2(CHANNELS)
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [CHW-1:0]    rd_addr,
  input  logic [PROD_W-1:0] prod_i,
  input  logic              wr_en,
  input  logic [CHW-1:0]    wr_addr,
  input  logic              first_i,
  output logic [ACC_W-1:0]  sum_o
);
  logic [ACC_W-1:0]  mem [CHANNELS];
  logic [ACC_W-1:0]  rd_q;
  logic [PROD_W-1:0] prod_q;
  logic [ACC_W-1:0]  prod_ext;

  generate
    if (SIGNED_P) begin : g_sext
      assign prod_ext = {{(ACC_W-PROD_W){prod_q[PROD_W-1]}}, prod_q};
    end else begin : g_zext
      assign prod_ext = {{(ACC_W-PROD_W){1'b0}}, prod_q};
    end
  endgenerate

  always_comb sum_o = first_i ? prod_ext : rd_q + prod_ext;

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_q   <= mem[rd_addr];
      prod_q <= prod_i;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= sum_o;
  end
endmodule

// File: rtl/corr_ctrl.sv
module corr_ctrl
  import corr_pkg::*;
#(
  parameter int CHANNELS = 512,
  localparam int CHW = $clog2(CHANNELS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] int_len,
  input  logic             in_valid,
  input  logic [CHW-1:0]   in_chan,
  output logic             first_o,
  output logic             final_o
);
  localparam logic [CHW-1:0] LAST_CH = CHW'(CHANNELS - 1);

  logic [LEN_W-1:0] cnt_q, cnt_d, len_q, len_d, len_req, cur_len;
  logic             opening;

  always_comb begin
    len_req = (int_len == '0) ? LEN_W'(1) : int_len;
    opening = (cnt_q == '0) && (in_chan == '0);
    cur_len = opening ? len_req : len_q;
    first_o = (cnt_q == '0);
    final_o = (cnt_q == cur_len - LEN_W'(1));
    cnt_d   = cnt_q;
    len_d   = len_q;
    if (in_valid && opening) len_d = len_req;
    if (in_valid && in_chan == LAST_CH) cnt_d = final_o ? '0 : cnt_q + LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= LEN_W'(1);
    end else if (in_valid) begin
      cnt_q <= cnt_d;
      len_q <= len_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (cnt_q < len_q)); // R4
  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    len_q != '0); // R5
endmodule

// File: rtl/corr_integrator.sv
module corr_integrator
  import corr_pkg::*;
#(
  parameter int CHANNELS = 512,
  localparam int CHW = $clog2(CHANNELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  int_len,
  input  logic              in_valid,
  input  logic [CHW-1:0]    in_chan,
  input  logic [SAMP_W-1:0] in_a_re,
  input  logic [SAMP_W-1:0] in_a_im,
  input  logic [SAMP_W-1:0] in_b_re,
  input  logic [SAMP_W-1:0] in_b_im,
  output logic              out_valid,
  output logic              out_last,
  output logic [CHW-1:0]    out_chan,
  output logic [ACC_W-1:0]  out_aa,
  output logic [ACC_W-1:0]  out_bb,
  output logic [ACC_W-1:0]  out_cr,
  output logic [ACC_W-1:0]  out_ci
);
  localparam logic [CHW-1:0] LAST_CH = CHW'(CHANNELS - 1);

  logic [PROD_W-1:0] prod [N_LANE];
  logic [ACC_W-1:0]  sums [N_LANE];
  logic              first0, final0;
  logic              v1_q, first1_q, final1_q;
  logic [CHW-1:0]    chan1_q;
  logic              dump_en;

  corr_cmul u_cmul (
    .a_re(in_a_re), .a_im(in_a_im), .b_re(in_b_re), .b_im(in_b_im),
    .p_aa(prod[0]), .p_bb(prod[1]), .p_cr(prod[2]), .p_ci(prod[3])
  );

  corr_ctrl #(.CHANNELS(CHANNELS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .int_len(int_len), .in_valid(in_valid),
    .in_chan(in_chan), .first_o(first0), .final_o(final0)
  );

  generate
    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
      corr_acc_lane #(.CHANNELS(CHANNELS), .SIGNED_P(g >= 2)) u_lane (
        .clk(clk), .rd_en(in_valid), .rd_addr(in_chan), .prod_i(prod[g]),
        .wr_en(v1_q), .wr_addr(chan1_q), .first_i(first1_q), .sum_o(sums[g])
      );
    end
  endgenerate

  // stage 1: memory read returns, product registered
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v1_q <= 1'b0;
    else        v1_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      chan1_q  <= in_chan;
      first1_q <= first0;
      final1_q <= final0;
    end
  end

  // stage 2: dump register
  always_comb dump_en = v1_q && final1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= dump_en;
  end

  always_ff @(posedge clk) begin
    if (dump_en) begin
      out_chan <= chan1_q;
      out_last <= (chan1_q == LAST_CH);
      out_aa   <= sums[0];
      out_bb   <= sums[1];
      out_cr   <= sums[2];
      out_ci   <= sums[3];
    end
  end

  AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && v1_q) |-> (in_chan != chan1_q)); // R8
  AST_LAST_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (out_chan == LAST_CH)); // R6
  AST_OUT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2)); // R7
  AST_AUTO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (prod[0] <= PROD_W'(2 ** (2 * SAMP_W - 1)))); // R1
endmodule

// File: tb/tb_corr_integrator.sv
module tb_corr_integrator;
  localparam int CH  = 8;
  localparam int CHW = $clog2(CH);

  logic clk = 1'b0;
  logic rst_n;
  logic [15:0] int_len;
  logic in_valid;
  logic [CHW-1:0] in_chan;
  logic [3:0] in_a_re, in_a_im, in_b_re, in_b_im;
  logic out_valid, out_last;
  logic [CHW-1:0] out_chan;
  logic [31:0] out_aa, out_bb, out_cr, out_ci;

  always #4 clk = ~clk;

  corr_integrator #(.CHANNELS(CH)) dut (
    .clk(clk), .rst_n(rst_n), .int_len(int_len), .in_valid(in_valid),
    .in_chan(in_chan), .in_a_re(in_a_re), .in_a_im(in_a_im),
    .in_b_re(in_b_re), .in_b_im(in_b_im), .out_valid(out_valid),
    .out_last(out_last), .out_chan(out_chan), .out_aa(out_aa),
    .out_bb(out_bb), .out_cr(out_cr), .out_ci(out_ci)
  );

  typedef struct {
    int due; int ch; bit last;
    logic [31:0] aa, bb, cr, ci;
  } exp_t;

  exp_t exp_q[$];
  int errors = 0, checks = 0, nidx = 0;
  string phase = "init";
  int m_cnt = 0, m_len = 1;
  int acc_aa[CH], acc_bb[CH], acc_cr[CH], acc_ci[CH];
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s [%s] cycle %0d: actual=%0h expected=%0h", req, phase, nidx, act, expv);
    end
  endtask

  task automatic check_out();
    if (exp_q.size() > 0 && exp_q[0].due == nidx) begin
      exp_t e = exp_q.pop_front();
      chk("R6 valid", 32'(out_valid), 32'd1);
      chk("R6 chan", 32'(out_chan), 32'(e.ch));
      chk("R6 last", 32'(out_last), 32'(e.last));
      chk("R1/R3 aa", out_aa, e.aa);
      chk("R1/R3 bb", out_bb, e.bb);
      chk("R2/R3 cr", out_cr, e.cr);
      chk("R2/R3 ci", out_ci, e.ci);
    end else begin
      chk("R7 idle", 32'(out_valid), 32'd0);
    end
  endtask

  // one cycle: check outputs at the falling edge, then drive the next input
  task automatic drive(input bit v, input int ch, input int ar, input int ai,
                       input int br, input int bi);
    @(negedge clk);
    nidx++;
    check_out();
    in_valid = v; in_chan = CHW'(ch);
    in_a_re = 4'(ar); in_a_im = 4'(ai); in_b_re = 4'(br); in_b_im = 4'(bi);
    if (v) begin
      int sar = $signed(4'(ar)), sai = $signed(4'(ai));
      int sbr = $signed(4'(br)), sbi = $signed(4'(bi));
      int paa = sar*sar + sai*sai, pbb = sbr*sbr + sbi*sbi;
      int pcr = sar*sbr + sai*sbi, pci = sai*sbr - sar*sbi;
      bit fin;
      if (m_cnt == 0 && ch == 0) m_len = (int_len == 0) ? 1 : int'(int_len); // R4 R5
      if (m_cnt == 0) begin
        acc_aa[ch] = paa; acc_bb[ch] = pbb; acc_cr[ch] = pcr; acc_ci[ch] = pci;
      end else begin
        acc_aa[ch] += paa; acc_bb[ch] += pbb; acc_cr[ch] += pcr; acc_ci[ch] += pci;
      end
      fin = (m_cnt == m_len - 1);
      if (fin) begin
        exp_t e;
        e.due = nidx + 2; e.ch = ch; e.last = (ch == CH - 1);
        e.aa = 32'(acc_aa[ch]); e.bb = 32'(acc_bb[ch]);
        e.cr = 32'(acc_cr[ch]); e.ci = 32'(acc_ci[ch]);
        exp_q.push_back(e);
      end
      if (ch == CH - 1) m_cnt = fin ? 0 : m_cnt + 1;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0);
  endtask

  // mode 0 random, 1 random with gaps, 2 extreme fixed samples
  task automatic spectrum(input int mode);
    for (int c = 0; c < CH; c++) begin
      if (mode == 1 && ($urandom % 3) == 0) idle(1 + $urandom % 2);
      if (mode == 2) drive(1, c, -8, -8, 7, -8);
      else drive(1, c, $urandom % 16, $urandom % 16, $urandom % 16, $urandom % 16);
    end
  endtask

  initial begin
    rst_n = 1'b0; int_len = 16'd1; in_valid = 1'b0; in_chan = '0;
    in_a_re = '0; in_a_im = '0; in_b_re = '0; in_b_im = '0;
    repeat (3) @(negedge clk);
    phase = "reset";
    chk("R9 reset", 32'(out_valid), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    phase = "len1";       // R1 R3 R6: every spectrum dumps
    int_len = 16'd1;
    for (int s = 0; s < 2; s++) spectrum(0);
    idle(3);

    phase = "len3 gaps";  // R3 R7 R8: idle cycles between channels
    int_len = 16'd3;
    for (int s = 0; s < 3; s++) spectrum(1);
    idle(3);

    phase = "len change"; // R4: change mid-integration deferred
    int_len = 16'd2;
    for (int c = 0; c < CH; c++) begin
      if (c == 3) int_len = 16'd5;
      drive(1, c, $urandom % 16, $urandom % 16, $urandom % 16, $urandom % 16);
    end
    spectrum(0);
    for (int s = 0; s < 5; s++) spectrum(1);
    idle(3);

    phase = "extreme";    // R2: sign handling with most negative samples
    int_len = 16'd2;
    for (int s = 0; s < 2; s++) spectrum(2);
    idle(3);

    phase = "len0";       // R5: zero length acts as one
    int_len = 16'd0;
    spectrum(0);
    idle(4);

    phase = "drain";
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R6 [%s]: actual=%0d pending expected=0", phase, exp_q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule